// File: doc/BRIEF.md
# Masked Broadcast Configuration Store

This block is the write-only configuration store for a four-channel device. It holds sixteen 5-bit banks. Twelve belong to the channels, three to each channel. Three more are broadcast banks, and the last is a bit mask. Software writes one bank per clock cycle through a plain strobe: an active-low write enable, an address and a data word. The contents of every bank are driven out in parallel, so downstream logic reads its settings directly from the store.

A write to a broadcast bank also reaches the bank in the same slot of every channel, so a setting shared by all channels needs one write instead of four. Each channel bank has a protect bit that decides whether that bank accepts broadcasts. The broadcast word itself can carry a force flag that overrides the protect bit. The mask bank decides which bit positions any write may change. The write port has no back-pressure: every strobe seen at a rising clock edge is taken in that cycle, and no write is ever stalled or queued.

Top module: `cfg_latch_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge, channel banks 0-11 load 5'b00001, broadcast banks 12-14 load 5'b00000 and mask bank 15 loads 5'b11111.
- R2: At an edge where `wr_n` is high, no bank changes, whatever `wr_addr` and `wr_data` hold.
- R3: A write to bank 0-14 changes exactly those bits of the addressed bank whose mask bit is 1, and loads them from `wr_data`. This includes bit 0 of a channel bank.
- R4: A write to bank 15 loads `wr_data` into the mask in full, whatever the mask held before.
- R5: Channel c (0-3) owns banks 3c to 3c+2. A write to broadcast bank 12+s (s = 0, 1, 2) also updates bank 3c+s of every channel.
- R6: Bit 0 of a channel bank is its broadcast-enable bit (1 = accept). A target bank whose bit 0 is 0 does not change on a broadcast whose `wr_data[0]` is 0.
- R7: A broadcast whose `wr_data[0]` is 1 is forced. It updates every target bank, including those whose broadcast-enable bit is 0.
- R8: A broadcast never changes bit 0 of any target channel bank.
- R9: Mask bit 0 has no effect on forcing: a forced broadcast still reaches disabled targets when mask bit 0 is 0.
- R10: A broadcast changes only those bits 4:1 of each enabled or forced target whose mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every write and every reset happens at its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| wr_addr | input | 4 | Bank selected by the write |
| wr_data | input | 5 | Data word written; on broadcast banks, bit 0 is also the force flag |
| bank_q | output | 80 | Contents of all banks; bank i appears on bits [5i+4:5i] |

## Verification
The bench goes after the protect bit. A design that let a broadcast overwrite bit 0 would silently re-enable or disable channels; one that ignored bit 0 would update protected banks. Forcing is tested with mask bit 0 cleared: a design that gated the force flag with the mask would leave disabled targets unchanged. Partial masks are applied to both direct and broadcast writes, which catches a design that masks one path but not the other. A mask write under an all-zero mask catches a design that masked bank 15 itself.

// File: rtl/cfg_latch_pkg.sv
package cfg_latch_pkg;

  typedef enum logic [1:0] {
    KIND_CHAN  = 2'd0,
    KIND_BCAST = 2'd1,
    KIND_MASK  = 2'd2
  } bank_kind_e;

  // Which role a bank index plays, given the number of channel banks.
  function automatic bank_kind_e kind_of(input int idx, input int chan_banks, input int bcast_banks);
    if (idx < chan_banks)                     return KIND_CHAN;
    else if (idx < chan_banks + bcast_banks)  return KIND_BCAST;
    else                                      return KIND_MASK;
  endfunction

  // Reset value of a bank of width w by its role.
  function automatic logic [31:0] reset_of(input bank_kind_e k, input int w);
    logic [31:0] ones;
    ones = (32'd1 << w) - 32'd1;
    case (k)
      KIND_CHAN:  return 32'd1;
      KIND_BCAST: return 32'd0;
      default:    return ones;
    endcase
  endfunction

endpackage

// File: rtl/cfg_bank_reg.sv
module cfg_bank_reg #(
  parameter int W = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bit_we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (q & ~bit_we) | (d & bit_we);
  end

endmodule

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode #(
  parameter int NUM_CH       = 4,
  parameter int BANKS_PER_CH = 3,
  parameter int BANK_W       = 5,
  localparam int CHAN_BANKS  = NUM_CH * BANKS_PER_CH,
  localparam int NUM_BANKS   = CHAN_BANKS + BANKS_PER_CH + 1,
  localparam int ADDR_W      = $clog2(NUM_BANKS)
) (
  input  logic                        wr_n,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic                        force_bit,
  input  logic [BANK_W-1:0]           mask_q,
  input  logic [CHAN_BANKS-1:0]       enable_vec,
  output logic [NUM_BANKS*BANK_W-1:0] bit_we
);
  import cfg_latch_pkg::*;

  localparam int MASK_IDX = NUM_BANKS - 1;

  // Direct-select line per bank.
  logic [NUM_BANKS-1:0] direct_sel;
  // One broadcast-hit line per slot.
  logic [BANKS_PER_CH-1:0] bcast_hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dsel
    assign direct_sel[b] = !wr_n && (wr_addr == ADDR_W'(b));
  end

  for (genvar s = 0; s < BANKS_PER_CH; s++) begin : g_bhit
    assign bcast_hit[s] = direct_sel[CHAN_BANKS + s];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
    if (kind_of(b, CHAN_BANKS, BANKS_PER_CH) == KIND_CHAN) begin : g_chan
      localparam int SLOT = b % BANKS_PER_CH;
      logic gate;
      assign gate = bcast_hit[SLOT] && (enable_vec[b] || force_bit);
      // Broadcast never touches bit 0; mask bit 0 plays no role in gating.
      assign bit_we[b*BANK_W +: BANK_W] =
          direct_sel[b] ? mask_q
        : gate          ? {mask_q[BANK_W-1:1], 1'b0}
        :                 '0;
    end else if (kind_of(b, CHAN_BANKS, BANKS_PER_CH) == KIND_BCAST) begin : g_bc
      assign bit_we[b*BANK_W +: BANK_W] = direct_sel[b] ? mask_q : '0;
    end else begin : g_mask
      assign bit_we[b*BANK_W +: BANK_W] = {BANK_W{direct_sel[b]}};
    end
  end

  // R5: at most one bank is directly selected by any write.
  always_comb begin
    a_r5_one_direct: assert ($onehot0(direct_sel) || $isunknown(wr_addr));
  end

  // R4: the mask bank's own write enable never depends on the mask.
  always_comb begin
    if (direct_sel[MASK_IDX])
      a_r4_mask_unmasked: assert (&bit_we[MASK_IDX*BANK_W +: BANK_W]);
  end

endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
  parameter int NUM_CH       = 4,
  parameter int BANKS_PER_CH = 3,
  parameter int BANK_W       = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  input  logic [$clog2(NUM_CH*BANKS_PER_CH+BANKS_PER_CH+1)-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_data,
  output logic [(NUM_CH*BANKS_PER_CH+BANKS_PER_CH+1)*BANK_W-1:0] bank_q
);
  import cfg_latch_pkg::*;

  localparam int CHAN_BANKS = NUM_CH * BANKS_PER_CH;
  localparam int NUM_BANKS  = CHAN_BANKS + BANKS_PER_CH + 1;
  localparam int ADDR_W     = $clog2(NUM_BANKS);
  localparam int MASK_IDX   = NUM_BANKS - 1;

  logic [NUM_BANKS*BANK_W-1:0] bit_we;
  logic [BANK_W-1:0]           mask_q;
  logic [CHAN_BANKS-1:0]       enable_vec;

  assign mask_q = bank_q[MASK_IDX*BANK_W +: BANK_W];

  for (genvar b = 0; b < CHAN_BANKS; b++) begin : g_en
    assign enable_vec[b] = bank_q[b*BANK_W];
  end

  cfg_wr_decode #(
    .NUM_CH      (NUM_CH),
    .BANKS_PER_CH(BANKS_PER_CH),
    .BANK_W      (BANK_W)
  ) u_dec (
    .wr_n      (wr_n),
    .wr_addr   (wr_addr),
    .force_bit (wr_data[0]),
    .mask_q    (mask_q),
    .enable_vec(enable_vec),
    .bit_we    (bit_we)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam bank_kind_e KIND = kind_of(b, CHAN_BANKS, BANKS_PER_CH);
    localparam logic [31:0] RV32 = reset_of(KIND, BANK_W);
    cfg_bank_reg #(
      .W      (BANK_W),
      .RST_VAL(RV32[BANK_W-1:0])
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .bit_we(bit_we[b*BANK_W +: BANK_W]),
      .d     (wr_data),
      .q     (bank_q[b*BANK_W +: BANK_W])
    );
  end

  // ---------------- assertions ----------------
  // R2: an idle strobe leaves every bank as it was.
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(bank_q));

  // R4: a mask write loads the data in full.
  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && wr_addr == ADDR_W'(MASK_IDX)) |=> (mask_q == $past(wr_data)));

  for (genvar b = 0; b < MASK_IDX; b++) begin : g_chk
    // R10: no write flips a bit whose mask bit was 0.
    a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && wr_addr != ADDR_W'(MASK_IDX)) |=>
      (((bank_q[b*BANK_W +: BANK_W] ^ $past(bank_q[b*BANK_W +: BANK_W])) & ~$past(mask_q)) == '0));

    if (b < CHAN_BANKS) begin : g_chan_chk
      localparam int SLOT = b % BANKS_PER_CH;
      // R8: broadcasts never change the protect bit.
      a_r8_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && wr_addr != ADDR_W'(b) && wr_addr != ADDR_W'(MASK_IDX)) |=>
        $stable(bank_q[b*BANK_W]));
      // R6: a disabled, unforced target keeps its contents.
      a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && wr_addr == ADDR_W'(CHAN_BANKS + SLOT) && !bank_q[b*BANK_W] && !wr_data[0]) |=>
        $stable(bank_q[b*BANK_W +: BANK_W]));
    end
  end

endmodule

// File: tb/tb_cfg_latch_bank.sv
module tb_cfg_latch_bank;
  localparam int NB = 16;
  localparam int W  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_n = 1'b1;
  logic [3:0]    wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [NB*W-1:0] bank_q;

  cfg_latch_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .bank_q(bank_q)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [W-1:0]    mdl [NB];
  logic [NB*W-1:0] exp_q [$];
  string           tag_q [$];

  function automatic logic [NB*W-1:0] pack_model();
    logic [NB*W-1:0] v;
    for (int b = 0; b < NB; b++) v[b*W +: W] = mdl[b];
    return v;
  endfunction

  function automatic void model_reset();
    for (int b = 0; b < 12; b++) mdl[b] = 5'b00001;
    for (int b = 12; b < 15; b++) mdl[b] = 5'b00000;
    mdl[15] = 5'b11111;
  endfunction

  // Expected effect of one write, taken from the requirements.
  function automatic void model_write(input int a, input logic [W-1:0] d);
    logic [W-1:0] mk, we;
    mk = mdl[15];
    if (a == 15) mdl[15] = d;
    else begin
      mdl[a] = (mdl[a] & ~mk) | (d & mk);
      if (a >= 12) begin
        for (int c = 0; c < 4; c++) begin
          int t;
          t = c * 3 + (a - 12);
          if (mdl[t][0] || d[0]) begin
            we = {mk[W-1:1], 1'b0};
            mdl[t] = (mdl[t] & ~we) | (d & we);
          end
        end
      end
    end
  endfunction

  task automatic drive_write(input int a, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    wr_n = 1'b0; wr_addr = 4'(a); wr_data = d;
    model_write(a, d);
    exp_q.push_back(pack_model()); tag_q.push_back(tag);
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic drive_idle(input int a, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    wr_n = 1'b1; wr_addr = 4'(a); wr_data = d;
    exp_q.push_back(pack_model()); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic drive_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b0; wr_addr = 4'd3; wr_data = 5'b10100;
    model_reset();
    exp_q.push_back(pack_model()); tag_q.push_back(tag);
    @(negedge clk);
    rst_n = 1'b1; wr_n = 1'b1;
  endtask

  // Monitor: compare right after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [NB*W-1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        n_checks++;
        if (bank_q !== e) begin
          n_fail++;
          $display("FAIL %s: bank_q actual=%h expected=%h", t, bank_q, e);
        end
      end
    end
  end

  initial begin
    model_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset contents.
    n_checks++;
    if (bank_q !== pack_model()) begin
      n_fail++;
      $display("FAIL R1: bank_q actual=%h expected=%h", bank_q, pack_model());
    end
    rst_n = 1'b1;
    drive_idle(0, 5'b11110, "R2 idle strobe on bank 0");
    drive_idle(15, 5'b00000, "R2 idle strobe on mask");
    drive_write(4, 5'b10110, "R3 direct write clears enable of bank 4");
    drive_write(13, 5'b01010, "R5 R6 R8 unforced broadcast slot 1");
    drive_write(13, 5'b11001, "R7 forced broadcast reaches bank 4");
    drive_write(15, 5'b00110, "R4 mask load");
    drive_write(0, 5'b11111, "R3 direct write under partial mask");
    drive_write(12, 5'b11000, "R10 broadcast under partial mask");
    drive_write(15, 5'b11111, "R4 mask back to all ones");
    drive_write(8, 5'b00000, "R3 disable bank 8");
    drive_write(15, 5'b11110, "R4 mask with bit 0 clear");
    drive_write(5, 5'b00000, "R3 masked bit 0 kept on direct write");
    drive_write(14, 5'b11101, "R9 forced broadcast with mask bit 0 clear");
    drive_write(14, 5'b01100, "R6 disabled bank 8 holds");
    drive_write(15, 5'b00000, "R4 mask all zero");
    drive_write(3, 5'b10101, "R10 R3 fully masked direct write");
    drive_write(15, 5'b10011, "R4 mask write not masked by zero mask");
    drive_reset("R1 reset mid-run");
    drive_write(12, 5'b10100, "R5 broadcast slot 0 after reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule